// File: doc/BRIEF.md
# Event Counter Bank with Shared Overflow Interrupt

A bank of up to 32 wide event counters for a processor core. Counter 0 counts clock cycles, counter 2 counts retired instructions, and counters 3 upward each follow a six-bit event code. The event code selects one strobe out of an input vector of event pulses. Index 1 is a hole: it reads as zero and ignores writes. Each counter can be frozen with its own inhibit bit. Counting can also be suppressed for the whole bank while the core runs in supervisor or user mode.

When a counter wraps from all-ones to zero, it sets a sticky overflow bit. A single interrupt line is high while any overflow bit is set together with its enable bit. Software arms a sampling period N by loading a counter with the two's complement of N. The overflow then fires on exactly the N-th counted event.

Access goes through a plain port: a write strobe with address and data, and a read path that returns data in the same cycle. The register map uses 7-bit addresses:

| Address | Contents |
|---------|----------|
| 0x00 | Inhibit, one bit per counter |
| 0x01 | Interrupt enable, one bit per counter |
| 0x02 | Overflow status; writing 1 to a bit clears it |
| 0x03 | Mode control: bit 11 disables counting in supervisor mode, bit 10 disables counting in user mode |
| 0x20 + i | Counter i |
| 0x40 + i | Event code of counter i |

Top module: `perf_counter_bank`

## Requirements
- R1: Counter 0 adds one on every clock edge where counting is allowed. Counter 2 adds one on each edge where `instr_ret` is high.
- R2: Index 1 holds no counter. Address 0x21 reads as zero, and writes to it are ignored.
- R3: A counter at index 3 or above adds one on each edge where bit k of `evt` is high, where k is its stored event code. Code 0 and codes above 42 never count. An event code reads back as its low 6 bits. Indices 0 and 2 have no event code and read 0 at 0x40 and 0x42.
- R4: A write to a counter loads the written value. A write wins over an increment in the same cycle.
- R5: A counter wraps from all-ones to zero and sets its overflow status bit on that edge. A counter preloaded with the two's complement of N overflows on the N-th counted event.
- R6: An overflow status bit stays set until a 1 is written to it at 0x02. A clear and a new overflow in the same cycle leave the bit set.
- R7: `irq` is high exactly while some counter has both its overflow bit and its interrupt enable bit set.
- R8: While its inhibit bit is 1, a counter holds its value. Writing all ones freezes every counter, and writing zero resumes them all.
- R9: `priv` encodes 2'b00 as user, 2'b01 as supervisor and 2'b11 as machine. With mode-control bit 11 set, no counter counts in supervisor mode. With bit 10 set, no counter counts in user mode. Machine mode is never gated.
- R10: During reset, all counters, event codes and control registers are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv | input | 2 | Current privilege mode of the core |
| evt | input | 43 | Event strobes; bit k is event code k |
| instr_ret | input | 1 | Instruction-retired strobe for counter 2 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr`, same cycle |
| irq | output | 1 | Combined overflow interrupt |

## Verification
The bench preloads a counter with minus three and looks at the edge where it wraps. A design that flags the overflow one event early or late fails there, as does one that leaves the counter at all-ones.

It also collides a write-1-to-clear of the status bit with a fresh wrap in the same cycle. A design that lets the clear win loses that overflow silently. A second collision puts a counter write and an increment in the same cycle; a design that adds the increment reads back one too high.

Event codes 0 and 50 are driven with every strobe high. A design that indexes past the event vector, or that counts code 0, shows a nonzero count. Mode gating is checked in each privilege mode with each disable bit set, so swapped bits 10 and 11 show up at once.

// File: rtl/perf_counter_bank.sv
module perf_counter_bank #(
  parameter int NUM_CTR   = 32,
  parameter int CTR_W     = 64,
  parameter int EVT_CODES = 43,
  parameter int CODE_W    = 6,
  parameter int AW        = 7,
  parameter int CTR_BASE  = 32,
  parameter int SEL_BASE  = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           priv,
  input  logic [EVT_CODES-1:0] evt,
  input  logic                 instr_ret,
  input  logic                 reg_we,
  input  logic [AW-1:0]        reg_addr,
  input  logic [CTR_W-1:0]     reg_wdata,
  output logic [CTR_W-1:0]     reg_rdata,
  output logic                 irq
);
  localparam int IDX_W     = $clog2(NUM_CTR);
  localparam int EVT_SPAN  = 1 << CODE_W;
  localparam logic [AW-1:0] A_INH  = AW'(0);
  localparam logic [AW-1:0] A_IEN  = AW'(1);
  localparam logic [AW-1:0] A_OVF  = AW'(2);
  localparam logic [AW-1:0] A_MODE = AW'(3);
  localparam int S_DIS_BIT = 11;
  localparam int U_DIS_BIT = 10;

  logic [NUM_CTR-1:0] inh_q, ien_q, ovf_q, wrap;
  logic dis_s_q, dis_u_q;
  logic [NUM_CTR-1:0][CTR_W-1:0]  cnt_all;
  logic [NUM_CTR-1:0][CODE_W-1:0] sel_all;
  logic [EVT_SPAN-1:0] evt_pad;
  logic mode_ok;

  assign evt_pad = EVT_SPAN'(evt) & ~EVT_SPAN'(1);
  assign mode_ok = !((priv == 2'b01 && dis_s_q) || (priv == 2'b00 && dis_u_q));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    if (i == 1) begin : g_hole
      assign cnt_all[i] = '0;
      assign sel_all[i] = '0;
      assign wrap[i]    = 1'b0;
    end else begin : g_real
      logic [CTR_W-1:0] cnt;
      logic hit, inc, cwr;
      assign cwr = reg_we && reg_addr == AW'(CTR_BASE + i);
      if (i == 0) begin : g_cyc
        assign hit = 1'b1;
        assign sel_all[i] = '0;
      end else if (i == 2) begin : g_ret
        assign hit = instr_ret;
        assign sel_all[i] = '0;
      end else begin : g_prog
        logic [CODE_W-1:0] sel;
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sel <= '0;
          else if (reg_we && reg_addr == AW'(SEL_BASE + i)) sel <= reg_wdata[CODE_W-1:0];
        assign hit = evt_pad[sel];
        assign sel_all[i] = sel;
      end
      assign inc     = hit && mode_ok && !inh_q[i];
      assign wrap[i] = inc && !cwr && (&cnt);
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) cnt <= '0;
        else if (cwr) cnt <= reg_wdata;
        else if (inc) cnt <= cnt + 1'b1;
      assign cnt_all[i] = cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_q   <= '0;
      ien_q   <= '0;
      ovf_q   <= '0;
      dis_s_q <= 1'b0;
      dis_u_q <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_INH) inh_q <= reg_wdata[NUM_CTR-1:0];
      if (reg_we && reg_addr == A_IEN) ien_q <= reg_wdata[NUM_CTR-1:0];
      if (reg_we && reg_addr == A_MODE) begin
        dis_s_q <= reg_wdata[S_DIS_BIT];
        dis_u_q <= reg_wdata[U_DIS_BIT];
      end
      ovf_q <= (ovf_q & ~((reg_we && reg_addr == A_OVF) ? reg_wdata[NUM_CTR-1:0] : '0)) | wrap;
    end
  end

  assign irq = |(ovf_q & ien_q);

  logic [AW-1:0] off_c, off_s;
  assign off_c = reg_addr - AW'(CTR_BASE);
  assign off_s = reg_addr - AW'(SEL_BASE);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_INH:  reg_rdata[NUM_CTR-1:0] = inh_q;
      A_IEN:  reg_rdata[NUM_CTR-1:0] = ien_q;
      A_OVF:  reg_rdata[NUM_CTR-1:0] = ovf_q;
      A_MODE: begin
        reg_rdata[S_DIS_BIT] = dis_s_q;
        reg_rdata[U_DIS_BIT] = dis_u_q;
      end
      default: begin
        if (off_c < AW'(NUM_CTR)) reg_rdata = cnt_all[off_c[IDX_W-1:0]];
        else if (off_s < AW'(NUM_CTR)) reg_rdata = CTR_W'(sel_all[off_s[IDX_W-1:0]]);
      end
    endcase
  end
endmodule

// File: rtl/perf_counter_bank_chk.sv
module perf_counter_bank_chk #(
  parameter int NUM_CTR  = 32,
  parameter int CTR_W    = 64,
  parameter int AW       = 7,
  parameter int CTR_BASE = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         priv,
  input logic               reg_we,
  input logic [AW-1:0]      reg_addr,
  input logic [CTR_W-1:0]   reg_wdata,
  input logic [CTR_W-1:0]   reg_rdata,
  input logic               irq,
  input logic [NUM_CTR-1:0] inh_q,
  input logic [NUM_CTR-1:0] ovf_q,
  input logic               dis_s_q,
  input logic [CTR_W-1:0]   cnt0
);
  logic wr0, wr_ovf, wr_ien0;
  assign wr0     = reg_we && reg_addr == AW'(CTR_BASE);
  assign wr_ovf  = reg_we && reg_addr == AW'(2);
  assign wr_ien0 = reg_we && reg_addr == AW'(1) && reg_wdata[NUM_CTR-1:0] == '0;

  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(CTR_BASE + 1)) |-> reg_rdata == '0); // R2
  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!inh_q[0] && priv == 2'b11 && !wr0) |=> cnt0 == $past(cnt0) + 1'b1); // R1
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr0 |=> cnt0 == $past(reg_wdata)); // R4
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!inh_q[0] && priv == 2'b11 && !wr0 && (&cnt0)) |=> ovf_q[0]); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ovf |=> ($past(ovf_q) & ~ovf_q) == '0); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ien0 |=> !irq); // R7
  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_q[0] && !wr0) |=> $stable(cnt0)); // R8
  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == 2'b01 && dis_s_q && !wr0) |=> $stable(cnt0)); // R9
endmodule

bind perf_counter_bank perf_counter_bank_chk #(
  .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .AW(AW), .CTR_BASE(CTR_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .priv(priv), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .inh_q(inh_q),
  .ovf_q(ovf_q), .dis_s_q(dis_s_q), .cnt0(cnt_all[0])
);

// File: tb/perf_counter_bank_tb_top.sv
`timescale 1ns/1ps
module perf_counter_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  priv = 2'b11;
  logic [42:0] evt = '0;
  logic        instr_ret = 1'b0;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  perf_counter_bank dut_i (.clk(clk), .rst_n(rst_n), .priv(priv), .evt(evt),
    .instr_ret(instr_ret), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  // {is_write, addr, data}
  localparam int NV = 19;
  localparam logic [71:0] VEC [NV] = '{
    {1'b1, 7'h00, 64'hFFFF_FFFF},
    {1'b1, 7'h25, 64'h1234_5678},
    {1'b0, 7'h25, 64'h1234_5678},
    {1'b1, 7'h21, 64'hDEAD},
    {1'b0, 7'h21, 64'h0},
    {1'b1, 7'h43, 64'h0C},
    {1'b0, 7'h43, 64'h0C},
    {1'b1, 7'h43, 64'hFF},
    {1'b0, 7'h43, 64'h3F},
    {1'b1, 7'h40, 64'h5},
    {1'b0, 7'h40, 64'h0},
    {1'b1, 7'h03, 64'hFFFF},
    {1'b0, 7'h03, 64'hC00},
    {1'b1, 7'h03, 64'h0},
    {1'b0, 7'h03, 64'h0},
    {1'b0, 7'h00, 64'hFFFF_FFFF},
    {1'b1, 7'h01, 64'h10},
    {1'b0, 7'h01, 64'h10},
    {1'b0, 7'h02, 64'h0}
  };
  localparam string VTAG [NV] = '{"R8","R4","R4","R2","R2","R3","R3","R3","R3",
    "R3","R3","R9","R9","R9","R9","R8","R7","R7","R6"};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [63:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_evt(input logic [42:0] v, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); evt = v;
      @(negedge clk); evt = '0;
    end
  endtask

  task automatic finish_run;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [63:0] v, v2;
    // R10 reset state
    repeat (2) @(negedge clk);
    rd(7'h20, v); check("R10 cnt0", v, 0);
    rd(7'h02, v); check("R10 ovf", v, 0);
    rd(7'h00, v); check("R10 inh", v, 0);
    check("R10 irq", {63'd0, irq}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][71]) wr(VEC[i][70:64], VEC[i][63:0]);
      else begin
        rd(VEC[i][70:64], v);
        check(VTAG[i], v, VEC[i][63:0]);
      end
    end

    // R1 cycle counter
    wr(7'h00, 0);
    wr(7'h20, 0);
    repeat (10) @(negedge clk);
    rd(7'h20, v); check("R1 cycles", v, 10);
    // R1 retired instructions
    wr(7'h22, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); instr_ret = 1'b1;
      @(negedge clk); instr_ret = 1'b0;
      @(negedge clk);
    end
    rd(7'h22, v); check("R1 instr", v, 3);

    // R3 event selection
    wr(7'h44, 12); wr(7'h47, 50); wr(7'h24, 0);
    pulse_evt('1, 3);
    pulse_evt(43'd1 << 13, 2);
    rd(7'h24, v); check("R3 code12", v, 3);
    rd(7'h26, v); check("R3 code0", v, 0);
    rd(7'h27, v); check("R3 code50", v, 0);

    // R5 preload -3 then wrap
    wr(7'h45, 7); wr(7'h02, 64'hFFFF_FFFF);
    wr(7'h25, 64'hFFFF_FFFF_FFFF_FFFD);
    pulse_evt(43'd1 << 7, 2);
    rd(7'h25, v); check("R5 before wrap", v, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(7'h02, v); check("R5 no early ovf", v & 64'h20, 0);
    pulse_evt(43'd1 << 7, 1);
    rd(7'h25, v); check("R5 wrapped", v, 0);
    rd(7'h02, v); check("R5 ovf set", v & 64'h20, 64'h20);
    check("R7 masked irq", {63'd0, irq}, 0);
    wr(7'h01, 64'h30);
    check("R7 irq on", {63'd0, irq}, 1);
    wr(7'h02, 64'h20);
    rd(7'h02, v); check("R6 cleared", v & 64'h20, 0);
    check("R7 irq off", {63'd0, irq}, 0);

    // R6 clear loses to new overflow
    wr(7'h25, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk);
    evt = 43'd1 << 7; reg_we = 1'b1; reg_addr = 7'h02; reg_wdata = 64'h20;
    @(negedge clk);
    evt = '0; reg_we = 1'b0;
    rd(7'h02, v); check("R6 wrap beats clear", v & 64'h20, 64'h20);
    wr(7'h02, 64'h20);

    // R4 write beats increment
    @(negedge clk);
    evt = 43'd1 << 7; reg_we = 1'b1; reg_addr = 7'h25; reg_wdata = 100;
    @(negedge clk);
    evt = '0; reg_we = 1'b0;
    rd(7'h25, v); check("R4 write wins", v, 100);

    // R8 inhibit
    wr(7'h00, 64'h1);
    rd(7'h20, v);
    repeat (5) @(negedge clk);
    rd(7'h20, v2); check("R8 held", v2, v);
    wr(7'h00, 64'hFFFF_FFFF);
    wr(7'h24, 0);
    pulse_evt('1, 2);
    rd(7'h24, v); check("R8 frozen", v, 0);
    wr(7'h00, 0);
    rd(7'h20, v);
    repeat (4) @(negedge clk);
    rd(7'h20, v2); check("R8 resumed", v2, v + 4);

    // R9 mode gating
    wr(7'h03, 64'h800);
    priv = 2'b01; rd(7'h20, v); repeat (5) @(negedge clk);
    rd(7'h20, v2); check("R9 sup blocked", v2, v);
    priv = 2'b00; rd(7'h20, v); repeat (5) @(negedge clk);
    rd(7'h20, v2); check("R9 user counts", v2, v + 5);
    wr(7'h03, 64'h400);
    rd(7'h20, v); repeat (5) @(negedge clk);
    rd(7'h20, v2); check("R9 user blocked", v2, v);
    priv = 2'b01; rd(7'h20, v); repeat (5) @(negedge clk);
    rd(7'h20, v2); check("R9 sup counts", v2, v + 5);
    wr(7'h03, 64'hC00);
    priv = 2'b11; rd(7'h20, v); repeat (5) @(negedge clk);
    rd(7'h20, v2); check("R9 machine counts", v2, v + 5);

    finish_run();
  end
endmodule